// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short global record of recent branch outcomes. That record is XORed with three bits of the branch's program counter. The result selects one of eight two-bit saturating counters, and the upper bit of the chosen counter is the guess. A fetch stage presents a 16-bit program counter. In the same cycle it receives the table index, the raw counter value and the taken bit. When the branch resolves, the back end returns the index it was given, along with the real outcome. The selected counter then moves one step toward that outcome, and the outcome enters the history register.

Each table entry is a four-state machine. The states are STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken update moves a counter one step: STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, and WEAK_T to STRONG_T. STRONG_T stays where it is. An untaken update moves it one step the other way: STRONG_T to WEAK_T, WEAK_T to WEAK_NT, and WEAK_NT to STRONG_NT. STRONG_NT stays where it is. A preload write forces any state directly. Two load ports support directed tests: one writes the history, the other writes table entries.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter is WEAK_NT (01) and the history is 000.
- R2: `pred_idx` equals `pred_pc[6:4]` XOR the history, in the same cycle that `pred_pc` is presented.
- R3: `pred_ctr` is the counter at `pred_idx`, and `pred_taken` is its upper bit (1 means taken).
- R4: A taken update raises the counter at `upd_idx` by one on the next edge, and a counter at 11 stays at 11.
- R5: An untaken update lowers the counter at `upd_idx` by one on the next edge, and a counter at 00 stays at 00.
- R6: Each update shifts its outcome into history bit 0 and drops bit 2, so the new history is {old[1:0], outcome}.
- R7: An update trains only the entry named by `upd_idx`, even if the history has changed since that index was produced. All other entries keep their values.
- R8: `hist_load` writes `hist_value` into the history on the next edge, and it overrides a shift requested in the same cycle.
- R9: `pre_we` writes `pre_val` into entry `pre_idx` on the next edge, and it overrides an update to the same entry in that cycle.
- R10: With history 011 and a table holding 00,10,11,01,00,01,11,10 at indices 0 to 7, PC 0x0100 yields index 3, counter 01, not taken. PC 0x2454 yields index 6, counter 11, taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 16 | Program counter of the branch to predict |
| pred_idx | output | 3 | Table index for `pred_pc` |
| pred_ctr | output | 2 | Counter value at `pred_idx` |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_idx | input | 3 | Index returned from prediction time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| hist_load | input | 1 | Write `hist_value` into history |
| hist_value | input | 3 | History value to load |
| pre_we | input | 1 | Table preload strobe |
| pre_idx | input | 3 | Entry to preload |
| pre_val | input | 2 | Counter value to preload |

## Verification
The counter-step properties assume that an update has not collided with a preload of the same entry. Collisions are excluded in the property guards and tested separately by the bench. The history properties assume that strobes are single-cycle and that inputs are steady at each rising edge. The bench meets this by changing every input only on the falling edge and by clearing each strobe after one cycle. Indices the bench returns on the update port are always ones it obtained or computed from the history model, so no out-of-range value can arise.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    localparam int CTR_W = 2;

    typedef enum logic [CTR_W-1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

endpackage

// File: rtl/gsh_index.sv
module gsh_index #(
    parameter int PC_W    = 16,
    parameter int IDX_LSB = 4,
    parameter int IDX_W   = 3
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);

    // hashed index: selected pc slice folded with global history
    assign idx = pc[IDX_LSB +: IDX_W] ^ hist;

endmodule

// File: rtl/gsh_history.sv
module gsh_history #(
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [HIST_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_q
);

    // load takes priority over a shift in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (load_en) begin
            hist_q <= load_val;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
        end
    end

endmodule

// File: rtl/gsh_counter_cell.sv
module gsh_counter_cell
    import gshare_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CTR_W-1:0] load_val,
    input  logic             train_en,
    input  logic             train_taken,
    output logic [CTR_W-1:0] ctr_q
);

    ctr_state_e state_q;
    ctr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTR_WEAK_NT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state: preload forces, otherwise one saturating step
    always_comb begin
        state_d = state_q;
        if (load_en) begin
            state_d = ctr_state_e'(load_val);
        end else if (train_en) begin
            unique case (state_q)
                CTR_STRONG_NT: state_d = train_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
                CTR_WEAK_NT:   state_d = train_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
                CTR_WEAK_T:    state_d = train_taken ? CTR_STRONG_T : CTR_WEAK_NT;
                CTR_STRONG_T:  state_d = train_taken ? CTR_STRONG_T : CTR_WEAK_T;
                default:       state_d = state_q;
            endcase
        end
    end

    // output
    assign ctr_q = state_q;

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int IDX_LSB = 4,
    parameter int HIST_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    output logic [HIST_W-1:0] pred_idx,
    output logic [CTR_W-1:0]  pred_ctr,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_taken,
    input  logic              hist_load,
    input  logic [HIST_W-1:0] hist_value,
    input  logic              pre_we,
    input  logic [HIST_W-1:0] pre_idx,
    input  logic [CTR_W-1:0]  pre_val
);

    localparam int ENTRIES = 1 << HIST_W;
    localparam int TBL_W   = ENTRIES * CTR_W;

    logic [HIST_W-1:0] ghist;
    logic [TBL_W-1:0]  tbl_flat;

    gsh_index #(
        .PC_W    (PC_W),
        .IDX_LSB (IDX_LSB),
        .IDX_W   (HIST_W)
    ) u_index (
        .pc   (pred_pc),
        .hist (ghist),
        .idx  (pred_idx)
    );

    gsh_history #(
        .HIST_W (HIST_W)
    ) u_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (hist_load),
        .load_val  (hist_value),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist_q    (ghist)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic hit_upd;
        logic hit_pre;
        assign hit_upd = upd_valid && (upd_idx == HIST_W'(g));
        assign hit_pre = pre_we && (pre_idx == HIST_W'(g));

        gsh_counter_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_en     (hit_pre),
            .load_val    (pre_val),
            .train_en    (hit_upd),
            .train_taken (upd_taken),
            .ctr_q       (tbl_flat[g*CTR_W +: CTR_W])
        );
    end

    // read mux
    always_comb begin
        pred_ctr = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (pred_idx == HIST_W'(e)) begin
                pred_ctr = tbl_flat[e*CTR_W +: CTR_W];
            end
        end
    end

    assign pred_taken = pred_ctr[CTR_W-1];

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk
    import gshare_pkg::*;
#(
    parameter int HIST_W = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             upd_valid,
    input logic [HIST_W-1:0]                upd_idx,
    input logic                             upd_taken,
    input logic                             hist_load,
    input logic [HIST_W-1:0]                hist_value,
    input logic                             pre_we,
    input logic [HIST_W-1:0]                pre_idx,
    input logic [CTR_W-1:0]                 pre_val,
    input logic [CTR_W-1:0]                 pred_ctr,
    input logic                             pred_taken,
    input logic [HIST_W-1:0]                ghist,
    input logic [(1<<HIST_W)*CTR_W-1:0]     tbl_flat
);

    localparam int ENTRIES = 1 << HIST_W;

    function automatic logic [CTR_W-1:0] entry_of(
        input logic [ENTRIES*CTR_W-1:0] t,
        input logic [HIST_W-1:0]        i
    );
        logic [CTR_W-1:0] r;
        r = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (i == HIST_W'(e)) r = t[e*CTR_W +: CTR_W];
        end
        return r;
    endfunction

    logic [CTR_W-1:0] upd_ent;
    logic             clean_upd;
    assign upd_ent   = entry_of(tbl_flat, upd_idx);
    assign clean_upd = upd_valid && !(pre_we && (pre_idx == upd_idx));

    assert_taken_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == pred_ctr[CTR_W-1]);

    assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clean_upd && upd_taken && (upd_ent != 2'b11)
        |=> entry_of(tbl_flat, $past(upd_idx)) == CTR_W'($past(upd_ent) + 2'd1));

    assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clean_upd && upd_taken && (upd_ent == 2'b11)
        |=> entry_of(tbl_flat, $past(upd_idx)) == 2'b11);

    assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clean_upd && !upd_taken && (upd_ent != 2'b00)
        |=> entry_of(tbl_flat, $past(upd_idx)) == CTR_W'($past(upd_ent) - 2'd1));

    assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clean_upd && !upd_taken && (upd_ent == 2'b00)
        |=> entry_of(tbl_flat, $past(upd_idx)) == 2'b00);

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !hist_load
        |=> ghist == {$past(ghist[HIST_W-2:0]), $past(upd_taken)});

    assert_hist_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hist_load |=> ghist == $past(hist_value));

    assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we |=> entry_of(tbl_flat, $past(pre_idx)) == $past(pre_val));

    assert_idle_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid && !pre_we |=> $stable(tbl_flat));

endmodule

bind gshare_predictor gshare_predictor_chk #(
    .HIST_W (HIST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_idx    (upd_idx),
    .upd_taken  (upd_taken),
    .hist_load  (hist_load),
    .hist_value (hist_value),
    .pre_we     (pre_we),
    .pre_idx    (pre_idx),
    .pre_val    (pre_val),
    .pred_ctr   (pred_ctr),
    .pred_taken (pred_taken),
    .ghist      (ghist),
    .tbl_flat   (tbl_flat)
);

// File: tb/test_gshare_predictor.sv
module test_gshare_predictor;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pred_pc = '0;
    logic [2:0]  pred_idx;
    logic [1:0]  pred_ctr;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_idx = '0;
    logic        upd_taken = 1'b0;
    logic        hist_load = 1'b0;
    logic [2:0]  hist_value = '0;
    logic        pre_we = 1'b0;
    logic [2:0]  pre_idx = '0;
    logic [1:0]  pre_val = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] hm;         // history model
    int         tm [8];     // table model

    always #(CLK_PERIOD/2) clk = ~clk;

    gshare_predictor i_gshare_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_idx   (pred_idx),
        .pred_ctr   (pred_ctr),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_idx    (upd_idx),
        .upd_taken  (upd_taken),
        .hist_load  (hist_load),
        .hist_value (hist_value),
        .pre_we     (pre_we),
        .pre_idx    (pre_idx),
        .pre_val    (pre_val)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_entry(input logic [2:0] idx, input string req);
        pred_pc = {9'd0, idx ^ hm, 4'd0};
        #1;
        chk(req, "index", int'(pred_idx), int'(idx));
        chk(req, "counter", int'(pred_ctr), tm[idx]);
        chk(req, "taken", int'(pred_taken), tm[idx] / 2);
    endtask

    task automatic check_hist(input string req);
        pred_pc = '0;
        #1;
        chk(req, "history", int'(pred_idx), int'(hm));
    endtask

    function automatic int model_step(input int v, input logic t);
        if (t) return (v == 3) ? 3 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic do_update(input logic [2:0] idx, input logic t);
        upd_valid = 1'b1; upd_idx = idx; upd_taken = t;
        step();
        upd_valid = 1'b0;
        tm[idx] = model_step(tm[idx], t);
        hm = {hm[1:0], t};
    endtask

    task automatic do_preload(input logic [2:0] idx, input logic [1:0] v);
        pre_we = 1'b1; pre_idx = idx; pre_val = v;
        step();
        pre_we = 1'b0;
        tm[idx] = int'(v);
    endtask

    task automatic do_hist_load(input logic [2:0] v);
        hist_load = 1'b1; hist_value = v;
        step();
        hist_load = 1'b0;
        hm = v;
    endtask

    task automatic t_reset();
        for (int e = 0; e < 8; e++) read_entry(3'(e), "R1");
        check_hist("R1");
        pred_pc = 16'h0050;
        #1;
        chk("R2", "index pc bits 101", int'(pred_idx), 5);
    endtask

    task automatic t_preload();
        int init [8] = '{0, 2, 3, 1, 0, 1, 3, 2};
        for (int e = 0; e < 8; e++) do_preload(3'(e), 2'(init[e]));
        for (int e = 0; e < 8; e++) read_entry(3'(e), "R9");
        read_entry(3'd2, "R3");
    endtask

    task automatic t_example();
        do_hist_load(3'b011);
        check_hist("R8");
        pred_pc = 16'h0100;
        #1;
        chk("R10", "pc0100 index", int'(pred_idx), 3);
        chk("R10", "pc0100 counter", int'(pred_ctr), 1);
        chk("R10", "pc0100 taken", int'(pred_taken), 0);
        pred_pc = 16'h2454;
        #1;
        chk("R10", "pc2454 index", int'(pred_idx), 6);
        chk("R10", "pc2454 counter", int'(pred_ctr), 3);
        chk("R10", "pc2454 taken", int'(pred_taken), 1);
        chk("R2", "xor index", int'(pred_idx), int'(3'b101 ^ 3'b011));
    endtask

    task automatic t_saturate();
        do_update(3'd0, 1'b0);
        read_entry(3'd0, "R5");
        for (int k = 0; k < 4; k++) begin
            do_update(3'd0, 1'b1);
            read_entry(3'd0, "R4");
        end
        chk("R4", "saturated high", tm[0], 3);
        for (int k = 0; k < 4; k++) begin
            do_update(3'd0, 1'b0);
            read_entry(3'd0, "R5");
        end
        chk("R5", "saturated low", tm[0], 0);
    endtask

    task automatic t_history();
        logic pat [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
        do_hist_load(3'b000);
        for (int k = 0; k < 4; k++) begin
            do_update(3'd5, pat[k]);
            check_hist("R6");
        end
        chk("R6", "final history", int'(hm), 3);
        // load and update together: load wins, entry still trains
        hist_load = 1'b1; hist_value = 3'b110;
        upd_valid = 1'b1; upd_idx = 3'd7; upd_taken = 1'b1;
        step();
        hist_load = 1'b0; upd_valid = 1'b0;
        tm[7] = model_step(tm[7], 1'b1);
        hm = 3'b110;
        check_hist("R8");
        read_entry(3'd7, "R8");
    endtask

    task automatic t_stale_index();
        logic [2:0] saved;
        int other;
        pred_pc = {9'd0, 3'd2 ^ hm, 4'd0};
        #1;
        saved = pred_idx;
        chk("R7", "captured index", int'(saved), 2);
        do_hist_load(3'b001);
        other = tm[3'd2 ^ 3'b110 ^ 3'b001];
        do_update(saved, 1'b1);
        read_entry(3'd2, "R7");
        for (int e = 0; e < 8; e++) read_entry(3'(e), "R7");
        chk("R7", "entry at new index", tm[3'd2 ^ 3'b110 ^ 3'b001], other);
    endtask

    task automatic t_collision();
        pre_we = 1'b1; pre_idx = 3'd4; pre_val = 2'd2;
        upd_valid = 1'b1; upd_idx = 3'd4; upd_taken = 1'b0;
        step();
        pre_we = 1'b0; upd_valid = 1'b0;
        tm[4] = 2;
        hm = {hm[1:0], 1'b0};
        read_entry(3'd4, "R9");
        check_hist("R6");
    endtask

    initial begin
        for (int e = 0; e < 8; e++) tm[e] = 1;
        hm = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preload();
        t_example();
        t_saturate();
        t_history();
        t_stale_index();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule